// File: doc/BRIEF.md
# Three-wire handshake byte shifter

This block moves single bytes between a host processor and a peripheral controller through an 8-bit shift data register. The host drives two active-low handshake lines: a transfer-active line and an acknowledge line. The device answers on an active-low request line. A direction input tells the engine whether the host is sending bytes to the device or collecting bytes from it. The engine only looks at the handshake lines when the host writes them, and it compares each write with the previous one.

In the host-to-device direction, every handshake change during a transfer latches the shift register into a 16-entry outbound store. When the transfer-active line is released, the engine signals a complete packet with its byte count. In the device-to-host direction, the device side first fills a 128-entry inbound store and announces a packet length. Each handshake change during a transfer then presents the next stored byte in the shift register. The request line tells the host that bytes are waiting, marks the end of an inbound packet, and follows the acknowledge line during the idle synchronisation exchange. Each byte move, each synchronisation step and each end of transfer raises a one-cycle shift interrupt pulse.

Top module: `hs_shifter`

## Requirements
- R1: After reset, req_n is 1, sr_irq is 0, pkt_done is 0 and sr_q is 0.
- R2: A host write (sr_wr) loads sr_wdata into the shift register, and sr_q shows it one cycle later. A delivery from the inbound store in the same cycle takes precedence.
- R3: If port_wr arrives with port_tip_n low and dir_out high, and either handshake line differs from the previous port write, the current sr_q is stored in the next outbound slot and sr_irq pulses for one cycle. A write with both lines unchanged stores nothing and raises no pulse.
- R4: Once 16 outbound bytes are held, further handshake changes store nothing and raise no sr_irq.
- R5: A port write that raises port_tip_n after the previous write had it low always pulses sr_irq. If any outbound bytes are held, pkt_done pulses for one cycle with pkt_count equal to their number, and the store empties. The stored bytes stay readable at out_raddr 0 to count-1.
- R6: If port_wr arrives with port_tip_n low and dir_out low, a handshake change moves the next unread inbound byte into sr_q and pulses sr_irq. When no bytes are unread, sr_q is unchanged and no pulse is raised.
- R7: Delivering the last byte of an inbound packet drives req_n to 1.
- R8: If the previous and the current port writes both have port_tip_n high and port_ack_n has changed, req_n takes the new port_ack_n level and sr_irq pulses.
- R9: A port write with port_tip_n high that is not a synchronisation step drives req_n to 0 when unread inbound bytes remain.
- R10: pkt_load restarts reading at byte 0, sets the length to pkt_len limited to 128, and pulses sr_irq in the next cycle. If the last written port_tip_n is high and the length is non-zero, req_n goes to 0.
- R11: in_wr stores in_data at inbound slot in_addr. Bytes are delivered in slot order starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Host write strobe for the handshake lines |
| port_tip_n | input | 1 | Transfer-active line value, active low |
| port_ack_n | input | 1 | Acknowledge line value, active low |
| dir_out | input | 1 | 1: host sends to device, 0: device sends to host |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Shift register write data |
| sr_q | output | 8 | Shift register contents |
| req_n | output | 1 | Device request line, active low |
| sr_irq | output | 1 | One-cycle shift interrupt pulse |
| out_raddr | input | 4 | Outbound store read address |
| out_rdata | output | 8 | Outbound store read data |
| pkt_done | output | 1 | One-cycle outbound packet complete strobe |
| pkt_count | output | 5 | Outbound byte count, valid with pkt_done |
| in_wr | input | 1 | Inbound store write strobe |
| in_addr | input | 7 | Inbound store write address |
| in_data | input | 8 | Inbound store write data |
| pkt_load | input | 1 | Start a new inbound packet |
| pkt_len | input | 8 | Inbound packet length |

## Verification
The bench sends handshake writes that change nothing and checks that they move no byte and raise no pulse. A design that acted on every write, or only on one line, would store duplicates or drop bytes. It fills the outbound store past 16 entries and checks the count reported at the end of the transfer. An engine without the limit would wrap the index and report a wrong or zero count. It loads a 200-byte inbound length and checks that the request line rises after exactly 128 deliveries, which exposes a missing or off-by-one clamp. It also checks the synchronisation exchange, where req_n must follow acknowledge, and a packet loaded during a transfer, where req_n must stay high until transfer-active rises.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef struct packed {
        logic tip_n;
        logic ack_n;
    } hs_lines_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_CAPTURE,
        EV_DELIVER,
        EV_SYNC,
        EV_IDLE
    } hs_event_e;

    localparam hs_lines_t LINES_RELEASED = '{tip_n: 1'b1, ack_n: 1'b1};

endpackage

// File: rtl/hs_line_tracker.sv
module hs_line_tracker
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  hs_lines_t lines_in,
    output hs_lines_t last,
    output logic      changed
);
    hs_lines_t last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= LINES_RELEASED;
        end else if (wr) begin
            last_q <= lines_in;
        end
    end

    assign last    = last_q;
    assign changed = (lines_in != last_q);
endmodule

// File: rtl/hs_out_buffer.sv
module hs_out_buffer #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          clear,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (push) begin
            count_q <= count_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem[count_q[AW-1:0]] <= push_data;
        end
    end

    assign rdata = mem[raddr];
    assign count = count_q;
    assign full  = (count_q >= CW'(DEPTH));
endmodule

// File: rtl/hs_in_buffer.sv
module hs_in_buffer #(
    parameter int DEPTH = 128,
    parameter int LEN_W = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [AW-1:0]    waddr,
    input  logic [7:0]       wdata,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             pop,
    output logic [7:0]       head,
    output logic             pending,
    output logic             last_one
);
    localparam int WW = (LEN_W > CW) ? LEN_W : CW;

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] rd_idx_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] len_clamped;

    always_comb begin
        if (WW'(load_len) > WW'(DEPTH)) begin
            len_clamped = CW'(DEPTH);
        end else begin
            len_clamped = CW'(load_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx_q <= '0;
            len_q    <= '0;
        end else if (load) begin
            rd_idx_q <= '0;
            len_q    <= len_clamped;
        end else if (pop) begin
            rd_idx_q <= rd_idx_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[waddr] <= wdata;
        end
    end

    assign head     = mem[rd_idx_q[AW-1:0]];
    assign pending  = (rd_idx_q < len_q);
    assign last_one = ((rd_idx_q + CW'(1)) >= len_q);
endmodule

// File: rtl/hs_shifter.sv
module hs_shifter
    import hs_pkg::*;
#(
    parameter int OUT_DEPTH = 16,
    parameter int IN_DEPTH  = 128,
    parameter int LEN_W     = 8,
    parameter int OUT_AW    = $clog2(OUT_DEPTH),
    parameter int OUT_CW    = $clog2(OUT_DEPTH + 1),
    parameter int IN_AW     = $clog2(IN_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_wr,
    input  logic              port_tip_n,
    input  logic              port_ack_n,
    input  logic              dir_out,
    input  logic              sr_wr,
    input  logic [7:0]        sr_wdata,
    output logic [7:0]        sr_q,
    output logic              req_n,
    output logic              sr_irq,
    input  logic [OUT_AW-1:0] out_raddr,
    output logic [7:0]        out_rdata,
    output logic              pkt_done,
    output logic [OUT_CW-1:0] pkt_count,
    input  logic              in_wr,
    input  logic [IN_AW-1:0]  in_addr,
    input  logic [7:0]        in_data,
    input  logic              pkt_load,
    input  logic [LEN_W-1:0]  pkt_len
);
    hs_lines_t         lines_now;
    hs_lines_t         lines_last;
    logic              lines_changed;
    logic              wr_eff;
    hs_event_e         ev;
    logic              closing;
    logic [OUT_CW-1:0] out_count;
    logic              out_full;
    logic [7:0]        in_head;
    logic              in_pending;
    logic              in_last;

    logic [7:0]        sr_r;
    logic              req_r;
    logic              irq_r;
    logic              done_r;
    logic [OUT_CW-1:0] count_r;

    assign lines_now = '{tip_n: port_tip_n, ack_n: port_ack_n};
    assign wr_eff    = port_wr & ~pkt_load;
    assign closing   = (ev == EV_IDLE) && !lines_last.tip_n;

    hs_line_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_eff),
        .lines_in (lines_now),
        .last     (lines_last),
        .changed  (lines_changed)
    );

    always_comb begin
        ev = EV_NONE;
        if (wr_eff) begin
            if (!lines_now.tip_n) begin
                if (dir_out) begin
                    if (lines_changed && !out_full) ev = EV_CAPTURE;
                end else begin
                    if (lines_changed && in_pending) ev = EV_DELIVER;
                end
            end else if (lines_last.tip_n && (lines_now.ack_n != lines_last.ack_n)) begin
                ev = EV_SYNC;
            end else begin
                ev = EV_IDLE;
            end
        end
    end

    hs_out_buffer #(
        .DEPTH (OUT_DEPTH),
        .AW    (OUT_AW),
        .CW    (OUT_CW)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .push      (ev == EV_CAPTURE),
        .push_data (sr_r),
        .clear     (closing),
        .raddr     (out_raddr),
        .rdata     (out_rdata),
        .count     (out_count),
        .full      (out_full)
    );

    hs_in_buffer #(
        .DEPTH (IN_DEPTH),
        .LEN_W (LEN_W),
        .AW    (IN_AW)
    ) u_in (
        .clk      (clk),
        .rst      (rst),
        .wr       (in_wr),
        .waddr    (in_addr),
        .wdata    (in_data),
        .load     (pkt_load),
        .load_len (pkt_len),
        .pop      (ev == EV_DELIVER),
        .head     (in_head),
        .pending  (in_pending),
        .last_one (in_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_r    <= '0;
            req_r   <= 1'b1;
            irq_r   <= 1'b0;
            done_r  <= 1'b0;
            count_r <= '0;
        end else begin
            irq_r  <= 1'b0;
            done_r <= 1'b0;

            if (ev == EV_DELIVER) begin
                sr_r <= in_head;
            end else if (sr_wr) begin
                sr_r <= sr_wdata;
            end

            if (pkt_load) begin
                irq_r <= 1'b1;
                if (lines_last.tip_n && (pkt_len != '0)) begin
                    req_r <= 1'b0;
                end
            end

            unique case (ev)
                EV_CAPTURE: irq_r <= 1'b1;
                EV_DELIVER: begin
                    irq_r <= 1'b1;
                    if (in_last) req_r <= 1'b1;
                end
                EV_SYNC: begin
                    irq_r <= 1'b1;
                    req_r <= lines_now.ack_n;
                end
                EV_IDLE: begin
                    if (closing) begin
                        irq_r <= 1'b1;
                        if (out_count != '0) begin
                            done_r  <= 1'b1;
                            count_r <= out_count;
                        end
                    end
                    if (in_pending) req_r <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign sr_q      = sr_r;
    assign req_n     = req_r;
    assign sr_irq    = irq_r;
    assign pkt_done  = done_r;
    assign pkt_count = count_r;
endmodule

// File: rtl/hs_shifter_checker.sv
module hs_shifter_checker #(
    parameter int OUT_DEPTH = 16,
    parameter int OUT_CW    = $clog2(OUT_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              port_wr,
    input logic              pkt_load,
    input logic              req_n,
    input logic              sr_irq,
    input logic              pkt_done,
    input logic [OUT_CW-1:0] pkt_count,
    input logic [OUT_CW-1:0] out_count
);
    // R4: the outbound store never holds more than its depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_count <= OUT_CW'(OUT_DEPTH));

    // R5: a completed packet reports a count between 1 and the depth
    a_r5_count_range: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_count != '0 && pkt_count <= OUT_CW'(OUT_DEPTH)));

    // R5: packet completion always comes with the shift interrupt
    a_r5_done_with_irq: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> sr_irq);

    // R10: loading an inbound packet pulses the interrupt next cycle
    a_r10_load_irq: assert property (@(posedge clk) disable iff (rst)
        pkt_load |=> sr_irq);

    // R9: the request line moves only after a port write or packet load
    a_r9_req_needs_access: assert property (@(posedge clk) disable iff (rst)
        !$stable(req_n) |-> $past(port_wr | pkt_load));

    // R3: an interrupt pulse is always caused by a port write or packet load
    a_r3_irq_needs_access: assert property (@(posedge clk) disable iff (rst)
        sr_irq |-> $past(port_wr | pkt_load));
endmodule

bind hs_shifter hs_shifter_checker #(
    .OUT_DEPTH (OUT_DEPTH),
    .OUT_CW    (OUT_CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_wr   (port_wr),
    .pkt_load  (pkt_load),
    .req_n     (req_n),
    .sr_irq    (sr_irq),
    .pkt_done  (pkt_done),
    .pkt_count (pkt_count),
    .out_count (out_count)
);

// File: tb/hs_shifter_tb_top.sv
`timescale 1ns/1ps
module hs_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_wr = 1'b0, port_tip_n = 1'b1, port_ack_n = 1'b1, dir_out = 1'b0;
    logic       sr_wr = 1'b0;
    logic [7:0] sr_wdata = '0;
    logic [7:0] sr_q;
    logic       req_n, sr_irq, pkt_done;
    logic [3:0] out_raddr = '0;
    logic [7:0] out_rdata;
    logic [4:0] pkt_count;
    logic       in_wr = 1'b0;
    logic [6:0] in_addr = '0;
    logic [7:0] in_data = '0;
    logic       pkt_load = 1'b0;
    logic [7:0] pkt_len = '0;

    int checks = 0;
    int errors = 0;
    int exp_done_q[$];

    always #10 clk = ~clk;

    hs_shifter dut_i (
        .clk, .rst, .port_wr, .port_tip_n, .port_ack_n, .dir_out,
        .sr_wr, .sr_wdata, .sr_q, .req_n, .sr_irq, .out_raddr, .out_rdata,
        .pkt_done, .pkt_count, .in_wr, .in_addr, .in_data, .pkt_load, .pkt_len
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every pkt_done must match the next expected count
    always @(negedge clk) begin
        if (!rst && pkt_done) begin
            if (exp_done_q.size() == 0) begin
                check(1'b0, "R5 unexpected pkt_done", int'(pkt_count), 0);
            end else begin
                int e;
                e = exp_done_q.pop_front();
                check(int'(pkt_count) == e, "R5 pkt_count", int'(pkt_count), e);
            end
        end
    end

    task automatic port_write(input logic tip, input logic ack);
        @(negedge clk);
        port_wr = 1'b1; port_tip_n = tip; port_ack_n = ack;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic sr_write(input logic [7:0] v);
        @(negedge clk);
        sr_wr = 1'b1; sr_wdata = v;
        @(negedge clk);
        sr_wr = 1'b0;
    endtask

    task automatic fill(input int idx, input logic [7:0] v);
        @(negedge clk);
        in_wr = 1'b1; in_addr = 7'(idx); in_data = v;
        @(negedge clk);
        in_wr = 1'b0;
    endtask

    task automatic load(input int len);
        @(negedge clk);
        pkt_load = 1'b1; pkt_len = 8'(len);
        @(negedge clk);
        pkt_load = 1'b0;
    endtask

    task automatic peek_out(input int a, input logic [7:0] e, input string tag);
        out_raddr = 4'(a);
        #1;
        check(out_rdata == e, tag, int'(out_rdata), int'(e));
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_n == 1'b1, "R1 req_n reset", int'(req_n), 1);
        check(sr_irq == 1'b0 && pkt_done == 1'b0, "R1 pulses reset", int'({sr_irq, pkt_done}), 0);
        check(sr_q == 8'h00, "R1 sr_q reset", int'(sr_q), 0);

        sr_write(8'hA5);
        check(sr_q == 8'hA5, "R2 sr write", int'(sr_q), 'hA5);

        // Host to device
        dir_out = 1'b1;
        port_write(1'b1, 1'b1);
        check(sr_irq == 1'b0, "R8 no change idle no irq", int'(sr_irq), 0);
        port_write(1'b0, 1'b1);
        check(sr_irq == 1'b1, "R3 capture irq", int'(sr_irq), 1);
        sr_write(8'h3C);
        port_write(1'b0, 1'b1);
        check(sr_irq == 1'b0, "R3 unchanged write no irq", int'(sr_irq), 0);
        port_write(1'b0, 1'b0);
        check(sr_irq == 1'b1, "R3 second capture irq", int'(sr_irq), 1);
        exp_done_q.push_back(2);
        port_write(1'b1, 1'b0);
        check(sr_irq == 1'b1, "R5 close irq", int'(sr_irq), 1);
        check(pkt_done == 1'b1, "R5 done strobe", int'(pkt_done), 1);
        peek_out(0, 8'hA5, "R5 out byte 0");
        peek_out(1, 8'h3C, "R5 out byte 1");

        // Fill past 16 entries
        for (int i = 0; i < 20; i++) begin
            sr_write(8'(8'h40 + i));
            port_write(1'b0, 1'(i[0]));
            if (i >= 16)
                check(sr_irq == 1'b0, "R4 full no irq", int'(sr_irq), 0);
        end
        exp_done_q.push_back(16);
        port_write(1'b1, 1'b1);
        check(pkt_done == 1'b1, "R4 done after overflow", int'(pkt_done), 1);
        peek_out(15, 8'h4F, "R4 last kept byte");

        // Sync exchange: tip held high
        port_write(1'b1, 1'b0);
        check(req_n == 1'b0 && sr_irq == 1'b1, "R8 req follows ack low", int'({req_n, sr_irq}), 1);
        port_write(1'b1, 1'b1);
        check(req_n == 1'b1 && sr_irq == 1'b1, "R8 req follows ack high", int'({req_n, sr_irq}), 3);

        // Device to host
        dir_out = 1'b0;
        fill(0, 8'h11); fill(1, 8'h22); fill(2, 8'h33);
        load(3);
        check(sr_irq == 1'b1, "R10 load irq", int'(sr_irq), 1);
        check(req_n == 1'b0, "R10 req low on load", int'(req_n), 0);
        port_write(1'b0, 1'b1);
        check(sr_q == 8'h11 && sr_irq == 1'b1, "R6 first byte", int'(sr_q), 'h11);
        check(req_n == 1'b0, "R7 req low mid packet", int'(req_n), 0);
        port_write(1'b0, 1'b0);
        check(sr_q == 8'h22, "R11 slot order", int'(sr_q), 'h22);
        port_write(1'b0, 1'b1);
        check(sr_q == 8'h33, "R6 third byte", int'(sr_q), 'h33);
        check(req_n == 1'b1, "R7 req high after last", int'(req_n), 1);
        port_write(1'b0, 1'b0);
        check(sr_q == 8'h33 && sr_irq == 1'b0, "R6 nothing left", int'({sr_irq, sr_q}), 'h33);
        port_write(1'b1, 1'b0);
        check(sr_irq == 1'b1 && pkt_done == 1'b0, "R5 close without bytes", int'({sr_irq, pkt_done}), 2);

        // Load during a transfer, request shown on release
        port_write(1'b0, 1'b1);
        fill(0, 8'h77); fill(1, 8'h88);
        load(2);
        check(req_n == 1'b1, "R10 no req while tip low", int'(req_n), 1);
        port_write(1'b1, 1'b1);
        check(req_n == 1'b0 && sr_irq == 1'b1, "R9 pending shown at release", int'({req_n, sr_irq}), 1);
        port_write(1'b0, 1'b1);
        check(sr_q == 8'h77, "R6 load restarts at 0", int'(sr_q), 'h77);
        port_write(1'b0, 1'b0);
        check(sr_q == 8'h88 && req_n == 1'b1, "R7 end of two-byte packet", int'(sr_q), 'h88);
        port_write(1'b1, 1'b0);

        // Length clamp
        for (int i = 0; i < 128; i++) fill(i, 8'(i) ^ 8'h5A);
        load(200);
        begin
            int bad = 0;
            for (int i = 0; i < 128; i++) begin
                port_write(1'b0, 1'(i[0]));
                if (sr_q != (8'(i) ^ 8'h5A)) bad++;
                if (i < 127 && req_n != 1'b0) bad++;
            end
            check(bad == 0, "R10 clamped stream bytes", bad, 0);
        end
        check(req_n == 1'b1, "R10 req high after 128", int'(req_n), 1);
        port_write(1'b0, 1'b0);
        check(sr_irq == 1'b0, "R10 no 129th byte", int'(sr_irq), 0);

        repeat (2) @(negedge clk);
        check(exp_done_q.size() == 0, "R5 all packets seen", exp_done_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule